// File: doc/BRIEF.md
# Masked XOR Scan Response Compactor

This block sits at the output end of a set of parallel scan chains. On every shift it folds the bit leaving each chain into a single parity bit with an XOR tree, giving an n-to-1 reduction of the data that must leave the chip. Chains that are known to carry unpredictable values can be removed from the fold: a per-chain mask, captured once per pattern on a load strobe, substitutes a fixed constant for each masked chain.

For diagnosis, a bypass mode routes one chosen chain straight to the output, so a failing pattern can be repeated and the offending bit located. A second, temporal stage XOR-accumulates a fixed number of consecutive first-stage bits and emits one bit with a one-cycle valid pulse, which multiplies the reduction ratio. This second stage is held cleared while bypass is active.

Top module: `scan_xor_compactor`

## Requirements
- R1: After reset, `cmp_bit`, `s2_bit` and `s2_valid` are 0 and every chain is unmasked.
- R2: On a cycle with `shift_en` high and `bypass_en` low, `cmp_bit` shows from the next cycle the XOR of all chain bits, with each masked chain counted as the constant 0.
- R3: Flipping an even number of unmasked chain bits leaves `cmp_bit` unchanged; flipping an odd number inverts it.
- R4: The mask register takes `mask_in` only on a cycle with `mask_load` high and applies from the next shift; `mask_in` has no effect otherwise. Bit i of the mask refers to chain i.
- R5: A masked chain's bit has no effect on `cmp_bit`.
- R6: On a shift with `bypass_en` high, `cmp_bit` shows from the next cycle `chain_out[bypass_sel]`, regardless of the mask.
- R7: On a cycle with `shift_en` low, `cmp_bit` keeps its value.
- R8: Outside bypass, every 4th shift raises `s2_valid` for exactly one cycle, in the same cycle `cmp_bit` shows that shift's result, with `s2_bit` equal to the XOR of the four first-stage bits of that group.
- R9: While `bypass_en` is high, `s2_valid` stays low and the group phase restarts, so the first valid after bypass comes 4 shifts after leaving it.
- R10: `s2_bit` changes only in a cycle where `s2_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_en | input | 1 | One shift of all chains happens this cycle |
| chain_out | input | 16 | Bit leaving each scan chain |
| mask_in | input | 16 | Mask value per chain, 1 = masked |
| mask_load | input | 1 | Capture `mask_in` into the mask register |
| bypass_en | input | 1 | Diagnostic mode: pass one chain through |
| bypass_sel | input | 4 | Chain chosen in bypass mode |
| cmp_bit | output | 1 | First-stage compacted bit, or bypassed chain bit |
| s2_bit | output | 1 | Second-stage compacted bit |
| s2_valid | output | 1 | One-cycle pulse marking a new `s2_bit` |

## Verification
The bench builds the block with its defaults: 16 chains, a group of 4 shifts and a fill constant of 0. With 16 chains every single-chain walk, every adjacent pair, every bypass select and every single-chain mask is swept in full, and the 4-shift group keeps the temporal stage's phase, its restart after bypass and its hold between pulses reachable within a few dozen shifts. Pseudo-random chain words on top of that, under several masks, compare both stages against parity computed in the bench.

// File: rtl/scancmp_pkg.sv
package scancmp_pkg;

  typedef enum logic {
    PATH_FOLD   = 1'b0,
    PATH_DIRECT = 1'b1
  } path_e;

  // Parity of a bit vector packed into 64 bits; unused upper bits must be 0.
  function automatic logic parity64(input logic [63:0] v);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 64; i++) p = p ^ v[i];
    return p;
  endfunction

endpackage

// File: rtl/scancmp_mask_reg.sv
module scancmp_mask_reg #(
  parameter int N_CHAINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [N_CHAINS-1:0] mask_in,
  output logic [N_CHAINS-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (load) mask_q <= mask_in;
  end

  // Mask only moves on a load strobe
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mask_q));

  p_mask_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mask_q == $past(mask_in)));

endmodule

// File: rtl/scancmp_fold.sv
module scancmp_fold #(
  parameter int   N_CHAINS = 16,
  parameter logic FILL     = 1'b0
) (
  input  logic [N_CHAINS-1:0] chain_bits,
  input  logic [N_CHAINS-1:0] mask,
  output logic [N_CHAINS-1:0] filtered,
  output logic                parity
);
  import scancmp_pkg::*;

  localparam int PADW = 64;

  generate
    for (genvar g = 0; g < N_CHAINS; g++) begin : g_fill
      assign filtered[g] = mask[g] ? FILL : chain_bits[g];
    end
  endgenerate

  logic [PADW-1:0] padded;
  always_comb begin
    padded = '0;
    padded[N_CHAINS-1:0] = filtered;
  end

  assign parity = parity64(padded);

  initial begin
    assert (N_CHAINS >= 2 && N_CHAINS <= PADW)
      else $error("chain count out of supported range");
  end

endmodule

// File: rtl/scancmp_temporal.sv
module scancmp_temporal #(
  parameter int ACC_DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_clear,
  input  logic step,
  input  logic bit_in,
  output logic grp_bit,
  output logic grp_valid
);

  localparam int CNT_W = (ACC_DEPTH > 2) ? $clog2(ACC_DEPTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACC_DEPTH - 1);

  logic [CNT_W-1:0] phase_q;
  logic             acc_q;
  logic             group_done;
  logic             folded;

  assign group_done = step && !hold_clear && (phase_q == LAST);
  assign folded     = acc_q ^ bit_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= '0;
      acc_q     <= 1'b0;
      grp_bit   <= 1'b0;
      grp_valid <= 1'b0;
    end else if (hold_clear) begin
      phase_q   <= '0;
      acc_q     <= 1'b0;
      grp_valid <= 1'b0;
    end else if (group_done) begin
      phase_q   <= '0;
      acc_q     <= 1'b0;
      grp_bit   <= folded;
      grp_valid <= 1'b1;
    end else if (step) begin
      phase_q   <= phase_q + 1'b1;
      acc_q     <= folded;
      grp_valid <= 1'b0;
    end else begin
      grp_valid <= 1'b0;
    end
  end

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |=> !grp_valid);

  p_clear_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clear |=> (!grp_valid && phase_q == '0));

  p_bit_moves_on_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(grp_bit) |-> grp_valid);

  initial begin
    assert (ACC_DEPTH >= 2) else $error("group depth must be at least 2");
  end

endmodule

// File: rtl/scan_xor_compactor.sv
module scan_xor_compactor #(
  parameter int   N_CHAINS  = 16,
  parameter int   ACC_DEPTH = 4,
  parameter logic FILL      = 1'b0,
  parameter int   SEL_W     = $clog2(N_CHAINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [N_CHAINS-1:0] chain_out,
  input  logic [N_CHAINS-1:0] mask_in,
  input  logic                mask_load,
  input  logic                bypass_en,
  input  logic [SEL_W-1:0]    bypass_sel,
  output logic                cmp_bit,
  output logic                s2_bit,
  output logic                s2_valid
);
  import scancmp_pkg::*;

  logic [N_CHAINS-1:0] mask_q;
  logic [N_CHAINS-1:0] filtered;
  logic                fold_parity;
  logic                direct_bit;
  logic                stage1_next;
  path_e               path;

  scancmp_mask_reg #(.N_CHAINS(N_CHAINS)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (mask_load),
    .mask_in (mask_in),
    .mask_q  (mask_q)
  );

  scancmp_fold #(.N_CHAINS(N_CHAINS), .FILL(FILL)) u_fold (
    .chain_bits (chain_out),
    .mask       (mask_q),
    .filtered   (filtered),
    .parity     (fold_parity)
  );

  assign path        = bypass_en ? PATH_DIRECT : PATH_FOLD;
  assign direct_bit  = chain_out[bypass_sel];
  assign stage1_next = (path == PATH_DIRECT) ? direct_bit : fold_parity;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmp_bit <= 1'b0;
    else if (shift_en) cmp_bit <= stage1_next;
  end

  scancmp_temporal #(.ACC_DEPTH(ACC_DEPTH)) u_temporal (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_clear (bypass_en),
    .step       (shift_en),
    .bit_in     (stage1_next),
    .grp_bit    (s2_bit),
    .grp_valid  (s2_valid)
  );

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cmp_bit));

  p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && bypass_en) |=> (cmp_bit == $past(chain_out[bypass_sel])));

  p_masked_filled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & filtered) == (mask_q & {N_CHAINS{FILL}})));

  p_unmasked_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mask_q & filtered) == (~mask_q & chain_out)));

endmodule

// File: tb/test_scan_xor_compactor.sv
module test_scan_xor_compactor;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_en = 1'b0;
  logic [N-1:0] chain_out = '0;
  logic [N-1:0] mask_in = '0;
  logic         mask_load = 1'b0;
  logic         bypass_en = 1'b0;
  logic [3:0]   bypass_sel = '0;
  logic         cmp_bit, s2_bit, s2_valid;

  int checks = 0;
  int errors = 0;

  // bench-side model state
  logic [N-1:0] m_mask = '0;
  logic         m_cmp = 1'b0;
  logic         m_s2 = 1'b0;
  logic         m_v = 1'b0;
  int           m_cnt = 0;
  logic         m_acc = 1'b0;
  logic [15:0]  lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  scan_xor_compactor i_scan_xor_compactor (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .chain_out(chain_out),
    .mask_in(mask_in), .mask_load(mask_load), .bypass_en(bypass_en),
    .bypass_sel(bypass_sel), .cmp_bit(cmp_bit), .s2_bit(s2_bit),
    .s2_valid(s2_valid));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // count ones among unmasked chains, the masked ones read as 0
  function automatic logic ref_parity(input logic [N-1:0] c, input logic [N-1:0] m);
    int ones;
    ones = 0;
    for (int i = 0; i < N; i++) if (c[i] && !m[i]) ones++;
    return logic'(ones % 2);
  endfunction

  task automatic step(input logic [N-1:0] c, input logic en, input logic byp,
                      input logic [3:0] sel, input string req);
    logic b;
    @(negedge clk);
    chain_out = c; shift_en = en; bypass_en = byp; bypass_sel = sel;
    @(posedge clk);
    #1;
    b = byp ? c[sel] : ref_parity(c, m_mask);
    if (en) m_cmp = b;
    m_v = 1'b0;
    if (byp) begin
      m_cnt = 0; m_acc = 1'b0;
    end else if (en) begin
      if (m_cnt == 3) begin
        m_s2 = m_acc ^ b; m_v = 1'b1; m_cnt = 0; m_acc = 1'b0;
      end else begin
        m_acc = m_acc ^ b; m_cnt++;
      end
    end
    check(req, cmp_bit, m_cmp);
    check("R8 valid", s2_valid, m_v);
    check("R10 s2_bit", s2_bit, m_s2);
    @(negedge clk);
    shift_en = 1'b0; bypass_en = 1'b0;
  endtask

  task automatic load_mask(input logic [N-1:0] m);
    @(negedge clk);
    mask_in = m; mask_load = 1'b1;
    @(posedge clk);
    #1;
    m_mask = m;
    @(negedge clk);
    mask_load = 1'b0;
    mask_in = ~m;   // should be ignored from now on (R4)
  endtask

  function automatic logic [15:0] next_lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ref_before;
    repeat (3) @(posedge clk);
    #1;
    check("R1 cmp_bit", cmp_bit, 1'b0);
    check("R1 s2_bit", s2_bit, 1'b0);
    check("R1 s2_valid", s2_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: mask starts clear -> all chains count
    step(16'h0001, 1'b1, 1'b0, 4'd0, "R1 mask clear");

    // R2: walk a single one across every chain
    for (int i = 0; i < N; i++) step(16'(1) << i, 1'b1, 1'b0, 4'd0, "R2 walk");

    // R3: adjacent pairs cancel, triples show
    for (int i = 0; i < N - 1; i++) step(16'(3) << i, 1'b1, 1'b0, 4'd0, "R3 pair");
    for (int i = 0; i < N - 2; i++) step(16'(7) << i, 1'b1, 1'b0, 4'd0, "R3 triple");

    // R7: idle cycles hold the output
    step(16'h0001, 1'b1, 1'b0, 4'd0, "R2 set");
    for (int i = 0; i < 3; i++) step(16'hFFFE, 1'b0, 1'b0, 4'd0, "R7 hold");

    // R5: mask each chain alone, drive only that chain
    for (int i = 0; i < N; i++) begin
      load_mask(16'(1) << i);
      step(16'(1) << i, 1'b1, 1'b0, 4'd0, "R5 masked alone");
      step(16'hFFFF, 1'b1, 1'b0, 4'd0, "R5 all ones");
    end

    // R4: mask_in differs from register while no load; must be ignored
    load_mask(16'h00F0);
    step(16'h0010, 1'b1, 1'b0, 4'd0, "R4 no load ignored");
    step(16'h0100, 1'b1, 1'b0, 4'd0, "R4 no load ignored");

    // R6: every bypass select, with the mask still set
    for (int i = 0; i < N; i++) begin
      step(16'(1) << i, 1'b1, 1'b1, 4'(i), "R6 select hit");
      step(~(16'(1) << i), 1'b1, 1'b1, 4'(i), "R6 select miss");
    end

    // R9: bypass in mid-group then resume; phase restarts
    load_mask(16'h0000);
    step(16'h0001, 1'b1, 1'b0, 4'd0, "R2 pre");
    step(16'h0001, 1'b1, 1'b0, 4'd0, "R2 pre");
    step(16'h0002, 1'b0, 1'b1, 4'd1, "R9 bypass idle");
    check("R9 quiet", s2_valid, 1'b0);
    for (int i = 0; i < 4; i++) step(16'h0003 << i, 1'b1, 1'b0, 4'd0, "R9 after");

    // R8: pseudo-random words under several masks, with idle gaps
    for (int k = 0; k < 4; k++) begin
      load_mask(lfsr ^ 16'h5A5A);
      for (int i = 0; i < 40; i++) begin
        lfsr = next_lfsr(lfsr);
        step(lfsr, (i % 5) != 2, 1'b0, 4'd0, "R8 random");
      end
    end

    // R3 at the ports: flip two unmasked chains, result unchanged
    load_mask(16'h0000);
    step(16'h1234, 1'b1, 1'b0, 4'd0, "R3 base");
    ref_before = cmp_bit;
    step(16'h1234 ^ 16'h8001, 1'b1, 1'b0, 4'd0, "R3 double flip");
    check("R3 cancel", cmp_bit, ref_before);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule